// File: doc/BRIEF.md
# Serial Host Register Port

This block is the slave side of a three-wire serial link through which a host microcontroller configures a receiver and collects what it has received. The host frames each transaction with an enable line, supplies a serial clock, and exchanges bits over a single bidirectional data line. The line is modelled here as an input, an output value and an output enable. The first two bits of every frame select the operation. The host can load a 9-bit setup word, fetch four status bits, or fetch a 128-bit received message.

All three serial wires are synchronised into the block's system clock, and their edges are found by oversampling. The serial clock must therefore run well below the system clock, with each phase lasting at least four system cycles. The setup fields leave the block as plain outputs: gain cut, band select and sleep code. The block also owns the data-ready flag. The surrounding receiver sets this flag when a message is complete. It is cleared once the host has read the whole message. The receiver-active flag, the quality code and the message bits come in as inputs.

Top module: `mcu_serial_port`

## Requirements
- R1: After reset, gain cut, band select and sleep code are all zero, data-ready is low, and the data line is not driven.
- R2: Each frame begins with a 2-bit operation code, sent high bit first: 01 is a setup write, 10 is a status read and 11 is a message read. Code 00 does nothing, and the line stays undriven until enable drops.
- R3: A setup write takes exactly 9 bits, least significant first. Bit 0 is the gain cut (0 = full gain, 1 = about 10 dB lower). Bits 1–2 are the band (00 = 868.3 MHz, 01 = 433.92 MHz, 10 = 315 MHz). Bits 3–8 are the sleep code. The word takes effect after the ninth bit, and the setup outputs change at no other time.
- R4: A setup word whose band field is 11 is discarded, and the previous setup is kept.
- R5: After a read code, the line stays undriven for one further serial clock period. The first read bit is driven from the falling edge after that period.
- R6: A status read returns four bits in this order: data-ready, receiver-active, quality bit 1, quality bit 0. The quality code counts the packets that were needed: 00 = one, 01 = two, 10 = three, 11 = four.
- R7: A message read returns 128 bits, starting at byte 0 bit 0 and ending at byte 15 bit 7. Within each byte the least significant bit comes first. Payload input bit 8*b+i holds byte b, bit i.
- R8: A pulse on the set input raises data-ready on the next cycle. Data-ready falls only when all 128 message bits have been read. A status read leaves it set.
- R9: Dropping enable in mid-frame aborts the frame. The line is released, a partial setup word is discarded, and data-ready is left unchanged.
- R10: Data-line input is sampled on rising serial clock edges. Read bits change after falling edges. The line is released at the falling edge that follows the final bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host |
| sen_i | input | 1 | Frame enable from host, high during a transaction |
| sdata_i | input | 1 | Data line as seen at the pad |
| sdata_o | output | 1 | Value driven onto the data line |
| sdata_oe_o | output | 1 | Drive enable for the data line |
| dr_set_i | input | 1 | Pulse: a complete message is available |
| rx_active_i | input | 1 | Receiver-active flag |
| quality_i | input | 2 | Packets-needed code |
| payload_i | input | 128 | Received message, byte b at bits 8*b+7..8*b |
| gain_cut_o | output | 1 | Setup: reduced front-end gain |
| band_sel_o | output | 2 | Setup: band selection |
| sleep_code_o | output | 6 | Setup: sleep interval code |
| data_ready_o | output | 1 | Data-ready flag |

## Verification
The hardest case to reach from the ports is a message read cut off partway through. Here the data-ready flag must survive, and the line must be released even though no final bit was sent. The stimulus first raises data-ready and then starts a message read. It drops enable after twenty bits and confirms that the line is released and the flag is still set. A full read that follows shows that the port was not left stuck mid-stream. The turnaround period is checked on every read as an expected undriven sample. A frame with a truncated setup word, and one with the reserved band, both show that the setup outputs do not move.

// File: rtl/mcu_ser_pkg.sv
package mcu_ser_pkg;
    localparam int OPC_W  = 2;
    localparam int STAT_W = 4;
    localparam logic [1:0] OPC_CFG_WR  = 2'b01;
    localparam logic [1:0] OPC_STAT_RD = 2'b10;
    localparam logic [1:0] OPC_DATA_RD = 2'b11;
    localparam logic [1:0] BAND_RESERVED = 2'b11;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_WR,
        ST_GAP,
        ST_RD,
        ST_HOLD
    } ser_state_e;
endpackage

// File: rtl/mcu_ser_sync.sv
module mcu_ser_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = async_i;
        for (int k = 1; k < DEPTH; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign sync_o = pipe_q[STAGES-1];
    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/mcu_ser_cfg.sv
module mcu_ser_cfg
    import mcu_ser_pkg::*;
#(
    parameter int SLEEP_W = 6,
    localparam int CFG_W  = 3 + SLEEP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] cfg_o
);
    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        // band field occupies bits 2:1; reserved code leaves setup untouched
        if (we_i && (wdata_i[2:1] != BAND_RESERVED)) begin
            cfg_d = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/mcu_ser_core.sv
module mcu_ser_core
    import mcu_ser_pkg::*;
#(
    parameter int CFG_W = 9,
    parameter int PAY_W = 128,
    localparam int CNT_W = $clog2(PAY_W),
    localparam int SIW   = $clog2(STAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_s,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              din_s,
    input  logic [STAT_W-1:0] stat_i,
    input  logic [PAY_W-1:0]  pay_i,
    output logic              dout_o,
    output logic              oe_o,
    output logic              cfg_we_o,
    output logic [CFG_W-1:0]  cfg_wdata_o,
    output logic              data_done_o
);
    localparam logic [CNT_W-1:0] CFG_LAST  = CNT_W'(CFG_W - 1);
    localparam logic [CNT_W-1:0] STAT_LAST = CNT_W'(STAT_W - 1);
    localparam logic [CNT_W-1:0] PAY_LAST  = CNT_W'(PAY_W - 1);

    typedef struct packed {
        ser_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [OPC_W-1:0]  opc;
        logic [CFG_W-1:0]  shreg;
        logic [STAT_W-1:0] snap;
        logic              is_data;
        logic              oe;
        logic              dout;
        logic              we;
        logic              done;
    } core_t;

    core_t r_d, r_q;
    logic [OPC_W-1:0] opc_next;
    logic [CNT_W-1:0] rd_last;
    logic             rd_bit;

    always_comb begin
        opc_next = {r_q.opc[0], din_s};
        rd_last  = r_q.is_data ? PAY_LAST : STAT_LAST;
        rd_bit   = r_q.is_data ? pay_i[r_q.cnt] : r_q.snap[r_q.cnt[SIW-1:0]];

        r_d      = r_q;
        r_d.we   = 1'b0;
        r_d.done = 1'b0;

        if (!en_s) begin
            r_d.st  = ST_OPC;
            r_d.cnt = '0;
            r_d.oe  = 1'b0;
        end else begin
            if (sclk_rise) begin
                unique case (r_q.st)
                    ST_OPC: begin
                        r_d.opc = opc_next;
                        if (r_q.cnt == CNT_W'(OPC_W - 1)) begin
                            r_d.cnt = '0;
                            unique case (opc_next)
                                OPC_CFG_WR:  r_d.st = ST_WR;
                                OPC_STAT_RD: begin
                                    r_d.st      = ST_GAP;
                                    r_d.is_data = 1'b0;
                                end
                                OPC_DATA_RD: begin
                                    r_d.st      = ST_GAP;
                                    r_d.is_data = 1'b1;
                                end
                                default:     r_d.st = ST_HOLD;
                            endcase
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                    ST_WR: begin
                        r_d.shreg = {din_s, r_q.shreg[CFG_W-1:1]};
                        if (r_q.cnt == CFG_LAST) begin
                            r_d.we = 1'b1;
                            r_d.st = ST_HOLD;
                        end else begin
                            r_d.cnt = r_q.cnt + 1'b1;
                        end
                    end
                    ST_GAP: begin
                        r_d.st   = ST_RD;
                        r_d.cnt  = '0;
                        r_d.snap = stat_i;
                    end
                    ST_RD: begin
                        if (r_q.oe) begin
                            if (r_q.cnt == rd_last) begin
                                r_d.st   = ST_HOLD;
                                r_d.done = r_q.is_data;
                            end else begin
                                r_d.cnt = r_q.cnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
            if (sclk_fall) begin
                if (r_q.st == ST_RD) begin
                    r_d.oe   = 1'b1;
                    r_d.dout = rd_bit;
                end else begin
                    r_d.oe = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_OPC, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign dout_o      = r_q.dout;
    assign oe_o        = r_q.oe;
    assign cfg_we_o    = r_q.we;
    assign cfg_wdata_o = r_q.shreg;
    assign data_done_o = r_q.done;
endmodule

// File: rtl/mcu_serial_port.sv
module mcu_serial_port
    import mcu_ser_pkg::*;
#(
    parameter int PAY_BYTES = 16,
    parameter int SLEEP_W   = 6,
    parameter int SYNC_ST   = 2,
    localparam int PAY_W    = PAY_BYTES * 8,
    localparam int CFG_W    = 3 + SLEEP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_i,
    input  logic               sen_i,
    input  logic               sdata_i,
    output logic               sdata_o,
    output logic               sdata_oe_o,
    input  logic               dr_set_i,
    input  logic               rx_active_i,
    input  logic [1:0]         quality_i,
    input  logic [PAY_W-1:0]   payload_i,
    output logic               gain_cut_o,
    output logic [1:0]         band_sel_o,
    output logic [SLEEP_W-1:0] sleep_code_o,
    output logic               data_ready_o
);
    logic [2:0] pins_s, pins_rise, pins_fall;
    logic       en_s, sclk_rise, sclk_fall, din_s;
    logic       cfg_we, data_done;
    logic [CFG_W-1:0]  cfg_wdata, cfg_word;
    logic [STAT_W-1:0] stat_vec;
    logic dr_d, dr_q;

    mcu_ser_sync #(.W(3), .STAGES(SYNC_ST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sdata_i, sen_i, sclk_i}),
        .sync_o  (pins_s),
        .rise_o  (pins_rise),
        .fall_o  (pins_fall)
    );

    assign sclk_rise = pins_rise[0];
    assign sclk_fall = pins_fall[0];
    assign en_s      = pins_s[1];
    assign din_s     = pins_s[2];

    // bit 0 leaves first: ready, active, quality high, quality low
    assign stat_vec = {quality_i[0], quality_i[1], rx_active_i, dr_q};

    mcu_ser_core #(.CFG_W(CFG_W), .PAY_W(PAY_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_s        (en_s),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .din_s       (din_s),
        .stat_i      (stat_vec),
        .pay_i       (payload_i),
        .dout_o      (sdata_o),
        .oe_o        (sdata_oe_o),
        .cfg_we_o    (cfg_we),
        .cfg_wdata_o (cfg_wdata),
        .data_done_o (data_done)
    );

    mcu_ser_cfg #(.SLEEP_W(SLEEP_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .wdata_i (cfg_wdata),
        .cfg_o   (cfg_word)
    );

    always_comb begin
        dr_d = dr_q;
        if (data_done) dr_d = 1'b0;
        if (dr_set_i)  dr_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dr_q <= 1'b0;
        else        dr_q <= dr_d;
    end

    assign gain_cut_o   = cfg_word[0];
    assign band_sel_o   = cfg_word[2:1];
    assign sleep_code_o = cfg_word[CFG_W-1:3];
    assign data_ready_o = dr_q;
endmodule

// File: rtl/mcu_serial_port_chk.sv
module mcu_serial_port_chk #(
    parameter int SLEEP_W = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en_s,
    input logic               cfg_we,
    input logic               data_done,
    input logic               oe,
    input logic               dr,
    input logic               dr_set,
    input logic               gain,
    input logic [1:0]         band,
    input logic [SLEEP_W-1:0] sleep
);
    assert_band_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        band != 2'b11);

    assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable({gain, band, sleep}));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> !oe);

    assert_dr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dr_set |=> dr);

    assert_dr_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dr && !data_done) |=> dr);
endmodule

bind mcu_serial_port mcu_serial_port_chk #(.SLEEP_W(SLEEP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s      (en_s),
    .cfg_we    (cfg_we),
    .data_done (data_done),
    .oe        (sdata_oe_o),
    .dr        (data_ready_o),
    .dr_set    (dr_set_i),
    .gain      (gain_cut_o),
    .band      (band_sel_o),
    .sleep     (sleep_code_o)
);

// File: tb/mcu_serial_port_bench.sv
module mcu_serial_port_bench;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sen = 1'b0, sdin = 1'b0;
    logic sdout, soe;
    logic dr_set = 1'b0, rx_act = 1'b0;
    logic [1:0] qual = 2'b00;
    logic [127:0] pay = '0;
    logic gain;
    logic [1:0] band;
    logic [5:0] sleep;
    logic drdy;

    int n_chk = 0, n_err = 0;
    logic mon_on = 1'b0;
    logic finished = 1'b0;

    typedef struct {
        logic  oe;
        logic  val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    mcu_serial_port u_mcu_serial_port (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sen_i(sen), .sdata_i(sdin),
        .sdata_o(sdout), .sdata_oe_o(soe), .dr_set_i(dr_set),
        .rx_active_i(rx_act), .quality_i(qual), .payload_i(pay),
        .gain_cut_o(gain), .band_sel_o(band), .sleep_code_o(sleep),
        .data_ready_o(drdy)
    );

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: host samples the line at each rising serial clock edge
    initial forever begin
        @(posedge sclk);
        if (mon_on) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_err++;
                $display("FAIL R5: actual unexpected sample oe=%0b expected none", soe);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (e.oe && (soe !== 1'b1 || sdout !== e.val)) begin
                    n_err++;
                    $display("FAIL %s: actual oe=%0b bit=%0b expected oe=1 bit=%0b",
                             e.tag, soe, sdout, e.val);
                end else if (!e.oe && soe !== 1'b0) begin
                    n_err++;
                    $display("FAIL %s: actual oe=%0b expected oe=0", e.tag, soe);
                end
            end
        end
    end

    task automatic sbit(input logic b);
        @(negedge clk) sdin = b;
        repeat (H) @(negedge clk);
        sclk = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic frame_start();
        @(negedge clk) sen = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_stop();
        repeat (H) @(negedge clk);
        sen = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [8:0] w, input int nbits);
        frame_start();
        sbit(1'b0);
        sbit(1'b1);
        for (int i = 0; i < nbits; i++) sbit(w[i]);
        frame_stop();
    endtask

    // driver: pushes expected samples, then clocks the frame
    task automatic do_read(input logic [1:0] op, input logic [127:0] bits,
                           input int n, input logic drive, input string tag);
        exp_t e;
        e.oe = 1'b0; e.val = 1'b0; e.tag = "R5";
        sb.push_back(e);
        for (int i = 0; i < n; i++) begin
            e.oe = drive; e.val = bits[i]; e.tag = tag;
            sb.push_back(e);
        end
        frame_start();
        sbit(op[1]);
        sbit(op[0]);
        mon_on = 1'b1;
        for (int i = 0; i <= n; i++) sbit(1'b0);
        mon_on = 1'b0;
        frame_stop();
        chk(sb.size(), 0, "R10 queue drained");
        chk(soe, 0, "R10 line released");
    endtask

    task automatic pulse_dr();
        @(negedge clk) dr_set = 1'b1;
        @(negedge clk) dr_set = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [127:0] pa, pb;
        for (int b = 0; b < 16; b++) begin
            pa[8*b +: 8] = 8'(b * 17 + 3);
            pb[8*b +: 8] = 8'(8'hC5 ^ (b * 29));
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(gain, 0, "R1 gain");
        chk(band, 0, "R1 band");
        chk(sleep, 0, "R1 sleep");
        chk(drdy, 0, "R1 ready");
        chk(soe, 0, "R1 line");

        // R3 setup write, LSB first
        cfg_write({6'b101101, 2'b01, 1'b1}, 9);
        chk(gain, 1, "R3 gain");
        chk(band, 1, "R3 band");
        chk(sleep, 6'b101101, "R3 sleep");
        cfg_write({6'h3f, 2'b10, 1'b0}, 9);
        chk(gain, 0, "R3 gain2");
        chk(band, 2, "R3 band2");
        chk(sleep, 6'h3f, "R3 sleep2");

        // R4 reserved band rejected
        cfg_write({6'h05, 2'b11, 1'b1}, 9);
        chk(band, 2, "R4 band kept");
        chk(gain, 0, "R4 gain kept");
        chk(sleep, 6'h3f, "R4 sleep kept");

        // R9 truncated write discarded
        cfg_write({6'h00, 2'b00, 1'b1}, 5);
        chk(gain, 0, "R9 gain kept");
        chk(sleep, 6'h3f, "R9 sleep kept");

        // R6 status reads
        rx_act = 1'b1; qual = 2'b10;
        do_read(2'b10, 128'(4'b0110), 4, 1'b1, "R6 status a");
        pulse_dr();
        chk(drdy, 1, "R8 set");
        rx_act = 1'b0; qual = 2'b01;
        do_read(2'b10, 128'(4'b1001), 4, 1'b1, "R6 status b");
        chk(drdy, 1, "R8 status read keeps");

        // R7 full message read clears ready
        pay = pa;
        do_read(2'b11, pa, 128, 1'b1, "R7 msg a");
        chk(drdy, 0, "R8 cleared by read");

        // R9 aborted message read
        pulse_dr();
        do_read(2'b11, pa, 20, 1'b1, "R9 partial");
        chk(drdy, 1, "R9 ready kept");

        pay = pb;
        do_read(2'b11, pb, 128, 1'b1, "R7 msg b");
        chk(drdy, 0, "R8 cleared b");

        // R2 null opcode leaves line undriven
        do_read(2'b00, '0, 6, 1'b0, "R2 null op");
        chk(band, 2, "R2 setup untouched");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule